// File: doc/BRIEF.md
# Elitist population store with replacement

This block keeps one genetic-algorithm population on chip: a chromosome array and a fitness array, always addressed with the same slot index. An initial population is written one slot per cycle through a load port. A sort request then starts a sorting pass that moves both arrays together until fitness is in descending order, so that the two weakest members always sit in the last two slots.

Once the population is ordered, the block accepts a pair of scored children over a valid/ready handshake. The fitter child is tested against the second-to-last slot and the other child against the last slot. Each child overwrites its slot only if its fitness is strictly larger. Any overwrite arms a resort that starts on its own, so the order holds again before the next pair is taken. Selection logic reads any slot at any time through a combinational read port. Storage stays at one population for every generation.

Top module: `elite_pool`

## Requirements
- R1: After reset every slot reads chromosome 0 and fitness 0, `busy` is 0 and `kid_ready` is 1.
- R2: A load with `load_en` high while `busy` is 0 writes `load_chrom` and `load_fit` into slot `load_idx` at that clock edge. The read port shows slot `rd_idx` combinationally. A load while `busy` is 1 is ignored.
- R3: Any accepted load drops `kid_ready` to 0 until a later sort has completed.
- R4: When `sort_go` is high while `busy` is 0, or a resort is pending, `busy` rises at that edge and stays high for exactly POP cycles. Fitness is then non-increasing from slot 0 to slot POP-1, and entries of equal fitness keep their earlier relative order.
- R5: Every chromosome moves with its own fitness value during a sort.
- R6: `kid_ready` is 1 only when `busy` is 0, the population is sorted and no resort is pending. `kid_valid` while `kid_ready` is 0 has no effect.
- R7: On an accepted pair, the child with the larger fitness is compared with slot POP-2 and the other child with slot POP-1. Child A counts as the larger one when the two are equal. A child whose fitness is strictly greater than its slot's fitness overwrites that slot's chromosome and fitness at the accept edge.
- R8: A child whose fitness is equal to or below its slot's fitness leaves that slot unchanged. If neither child replaces, no sort starts and `kid_ready` stays 1.
- R9: If any slot was replaced, `kid_ready` is 0 from the next cycle and a sort starts at the following edge without any request.
- R10: `sort_go` while `busy` is 1 neither lengthens nor restarts the running sort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_en | input | 1 | Write one slot of the initial population |
| load_idx | input | IDX_W | Slot written by a load |
| load_chrom | input | CHROM_W | Chromosome to load |
| load_fit | input | FIT_W | Fitness to load (unsigned) |
| sort_go | input | 1 | Request a full sort |
| rd_idx | input | IDX_W | Slot shown on the read port |
| rd_chrom | output | CHROM_W | Chromosome of slot `rd_idx` |
| rd_fit | output | FIT_W | Fitness of slot `rd_idx` |
| kid_valid | input | 1 | A scored child pair is offered |
| kid_ready | output | 1 | A child pair can be accepted |
| kid_a_chrom | input | CHROM_W | Chromosome of child A |
| kid_a_fit | input | FIT_W | Fitness of child A |
| kid_b_chrom | input | CHROM_W | Chromosome of child B |
| kid_b_fit | input | FIT_W | Fitness of child B |
| busy | output | 1 | Sort in progress |

## Verification
The hardest case to reach from the ports is a child pair that sits exactly on the replacement boundary: children equal to the weak slots, a tie between the children, or a pair where only one side wins. These cases also have to come while a resort is pending or a sort is running. The stimulus reads the current weak fitness values from the bench's own model and builds children equal to, one above and below them. It also pushes loads, sort requests and child offers into the middle of a running sort. A long run of random pairs then drives many replace-and-resort rounds over a population full of duplicate fitness values, where a stable order is easy to break.

// File: rtl/elite_pkg.sv
package elite_pkg;
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_SORT = 1'b1
   } pool_st_e;
endpackage

// File: rtl/elite_cx.sv
// Compare-exchange cell: larger key leaves on the hi side; equal keys keep order.
module elite_cx #(
   parameter int KW = 16,
   parameter int DW = 16
) (
   input  logic [KW-1:0] a_k,
   input  logic [DW-1:0] a_d,
   input  logic [KW-1:0] b_k,
   input  logic [DW-1:0] b_d,
   output logic [KW-1:0] hi_k,
   output logic [DW-1:0] hi_d,
   output logic [KW-1:0] lo_k,
   output logic [DW-1:0] lo_d
);
   logic swap;
   assign swap = a_k < b_k;
   assign hi_k = swap ? b_k : a_k;
   assign hi_d = swap ? b_d : a_d;
   assign lo_k = swap ? a_k : b_k;
   assign lo_d = swap ? a_d : b_d;
endmodule

// File: rtl/elite_sort_seq.sv
// Phase sequencer for the transposition network: POP phases, one per clock.
module elite_sort_seq
   import elite_pkg::*;
#(
   parameter int POP = 32,
   localparam int PW = $clog2(POP)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go_i,
   output logic start_o,
   output logic busy_o,
   output logic odd_o,
   output logic last_o
);
   pool_st_e       st_q;
   logic [PW-1:0]  ph_q;

   assign busy_o  = (st_q == ST_SORT);
   assign start_o = (st_q == ST_IDLE) && go_i;
   assign last_o  = busy_o && (ph_q == PW'(POP - 1));
   assign odd_o   = ph_q[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         ph_q <= '0;
      end else begin
         case (st_q)
            ST_IDLE: begin
               if (go_i) begin
                  st_q <= ST_SORT;
                  ph_q <= '0;
               end
            end
            default: begin
               if (last_o) begin
                  st_q <= ST_IDLE;
                  ph_q <= '0;
               end else begin
                  ph_q <= ph_q + 1'b1;
               end
            end
         endcase
      end
   end
endmodule

// File: rtl/elite_child_pick.sv
// Ranks the child pair and decides which weak slots each child displaces.
module elite_child_pick #(
   parameter int CW = 16,
   parameter int FW = 16
) (
   input  logic [CW-1:0] a_c,
   input  logic [FW-1:0] a_f,
   input  logic [CW-1:0] b_c,
   input  logic [FW-1:0] b_f,
   input  logic [FW-1:0] t2_f,
   input  logic [FW-1:0] t1_f,
   output logic [CW-1:0] hi_c,
   output logic [FW-1:0] hi_f,
   output logic [CW-1:0] lo_c,
   output logic [FW-1:0] lo_f,
   output logic          hi_wins,
   output logic          lo_wins
);
   logic b_up;
   assign b_up    = b_f > a_f;
   assign hi_c    = b_up ? b_c : a_c;
   assign hi_f    = b_up ? b_f : a_f;
   assign lo_c    = b_up ? a_c : b_c;
   assign lo_f    = b_up ? a_f : b_f;
   assign hi_wins = hi_f > t2_f;
   assign lo_wins = lo_f > t1_f;
endmodule

// File: rtl/elite_pool.sv
module elite_pool
   import elite_pkg::*;
#(
   parameter int POP     = 32,
   parameter int CHROM_W = 16,
   parameter int FIT_W   = 16,
   localparam int IDX_W  = $clog2(POP)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load_en,
   input  logic [IDX_W-1:0]   load_idx,
   input  logic [CHROM_W-1:0] load_chrom,
   input  logic [FIT_W-1:0]   load_fit,
   input  logic               sort_go,
   input  logic [IDX_W-1:0]   rd_idx,
   output logic [CHROM_W-1:0] rd_chrom,
   output logic [FIT_W-1:0]   rd_fit,
   input  logic               kid_valid,
   output logic               kid_ready,
   input  logic [CHROM_W-1:0] kid_a_chrom,
   input  logic [FIT_W-1:0]   kid_a_fit,
   input  logic [CHROM_W-1:0] kid_b_chrom,
   input  logic [FIT_W-1:0]   kid_b_fit,
   output logic               busy
);
   localparam int T2 = POP - 2;
   localparam int T1 = POP - 1;

   if (POP < 4) begin : g_bad_pop
      $error("elite_pool: POP must be at least 4");
   end
   if (CHROM_W < 1 || FIT_W < 1) begin : g_bad_w
      $error("elite_pool: widths must be positive");
   end

   logic [CHROM_W-1:0] chrom_q [POP];
   logic [FIT_W-1:0]   fit_q   [POP];
   logic [CHROM_W-1:0] chrom_n [POP];
   logic [FIT_W-1:0]   fit_n   [POP];

   logic order_ok_q, pend_q;
   logic start, last, odd;
   logic load_acc, kid_acc, rep;

   elite_sort_seq #(.POP(POP)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .go_i    (sort_go || pend_q),
      .start_o (start),
      .busy_o  (busy),
      .odd_o   (odd),
      .last_o  (last)
   );

   logic [CHROM_W-1:0] hi_c, lo_c;
   logic [FIT_W-1:0]   hi_f, lo_f;
   logic               hi_wins, lo_wins, wr_hi, wr_lo;

   elite_child_pick #(.CW(CHROM_W), .FW(FIT_W)) u_pick (
      .a_c     (kid_a_chrom),
      .a_f     (kid_a_fit),
      .b_c     (kid_b_chrom),
      .b_f     (kid_b_fit),
      .t2_f    (fit_q[T2]),
      .t1_f    (fit_q[T1]),
      .hi_c    (hi_c),
      .hi_f    (hi_f),
      .lo_c    (lo_c),
      .lo_f    (lo_f),
      .hi_wins (hi_wins),
      .lo_wins (lo_wins)
   );

   assign kid_ready = !busy && order_ok_q && !pend_q;
   assign kid_acc   = kid_valid && kid_ready;
   assign load_acc  = load_en && !busy;
   assign wr_hi     = kid_acc && hi_wins;
   assign wr_lo     = kid_acc && lo_wins;
   assign rep       = wr_hi || wr_lo;

   // Compare-exchange cells on every boundary between neighbouring slots.
   logic [FIT_W-1:0]   cx_hk [POP-1];
   logic [CHROM_W-1:0] cx_hd [POP-1];
   logic [FIT_W-1:0]   cx_lk [POP-1];
   logic [CHROM_W-1:0] cx_ld [POP-1];

   for (genvar b = 0; b < POP - 1; b++) begin : g_cx
      elite_cx #(.KW(FIT_W), .DW(CHROM_W)) u_cx (
         .a_k  (fit_q[b]),
         .a_d  (chrom_q[b]),
         .b_k  (fit_q[b+1]),
         .b_d  (chrom_q[b+1]),
         .hi_k (cx_hk[b]),
         .hi_d (cx_hd[b]),
         .lo_k (cx_lk[b]),
         .lo_d (cx_ld[b])
      );
   end

   // Next value of each slot: sort phase, then replacement, then load, else hold.
   for (genvar s = 0; s < POP; s++) begin : g_slot
      localparam bit S_ODD = (s % 2) == 1;
      logic [FIT_W-1:0]   srt_k;
      logic [CHROM_W-1:0] srt_d;
      logic               up_act, dn_act, ld_hit;

      if (s == 0) begin : g_first
         assign up_act = (odd == S_ODD);
         assign dn_act = 1'b0;
         assign srt_k  = up_act ? cx_hk[s] : fit_q[s];
         assign srt_d  = up_act ? cx_hd[s] : chrom_q[s];
      end else if (s == POP - 1) begin : g_final
         assign up_act = 1'b0;
         assign dn_act = (odd != S_ODD);
         assign srt_k  = dn_act ? cx_lk[s-1] : fit_q[s];
         assign srt_d  = dn_act ? cx_ld[s-1] : chrom_q[s];
      end else begin : g_mid
         assign up_act = (odd == S_ODD);
         assign dn_act = (odd != S_ODD);
         assign srt_k  = up_act ? cx_hk[s] : (dn_act ? cx_lk[s-1] : fit_q[s]);
         assign srt_d  = up_act ? cx_hd[s] : (dn_act ? cx_ld[s-1] : chrom_q[s]);
      end

      assign ld_hit = load_acc && (load_idx == IDX_W'(s));

      if (s == T2) begin : g_t2
         assign fit_n[s]   = busy ? srt_k : (wr_hi ? hi_f : (ld_hit ? load_fit : fit_q[s]));
         assign chrom_n[s] = busy ? srt_d : (wr_hi ? hi_c : (ld_hit ? load_chrom : chrom_q[s]));
      end else if (s == T1) begin : g_t1
         assign fit_n[s]   = busy ? srt_k : (wr_lo ? lo_f : (ld_hit ? load_fit : fit_q[s]));
         assign chrom_n[s] = busy ? srt_d : (wr_lo ? lo_c : (ld_hit ? load_chrom : chrom_q[s]));
      end else begin : g_body
         assign fit_n[s]   = busy ? srt_k : (ld_hit ? load_fit : fit_q[s]);
         assign chrom_n[s] = busy ? srt_d : (ld_hit ? load_chrom : chrom_q[s]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < POP; i++) begin
            chrom_q[i] <= '0;
            fit_q[i]   <= '0;
         end
      end else begin
         chrom_q <= chrom_n;
         fit_q   <= fit_n;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         order_ok_q <= 1'b1;
         pend_q     <= 1'b0;
      end else begin
         if (last) begin
            order_ok_q <= 1'b1;
         end else if (load_acc) begin
            order_ok_q <= 1'b0;
         end
         if (rep) begin
            pend_q <= 1'b1;
         end else if (start) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign rd_chrom = (int'(rd_idx) < POP) ? chrom_q[rd_idx] : '0;
   assign rd_fit   = (int'(rd_idx) < POP) ? fit_q[rd_idx]   : '0;
endmodule

// File: rtl/elite_pool_chk.sv
module elite_pool_chk #(
   parameter int POP = 32,
   parameter int FW  = 16,
   localparam int IW = $clog2(POP)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          kid_ready,
   input logic          kid_valid,
   input logic          load_en,
   input logic [IW-1:0] rd_idx,
   input logic [FW-1:0] rd_fit,
   input logic [FW-1:0] fit_q [POP],
   input logic          rep
);
   int run_q;
   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= 0;
      else        run_q <= busy ? run_q + 1 : 0;
   end

   AST_READY_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !kid_ready); // R6

   AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_q < POP)); // R4

   AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (run_q == POP)); // R4

   AST_RESORT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      rep |=> (!kid_ready ##1 busy)); // R9

   AST_WEAK_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (kid_valid && kid_ready && !load_en) |=>
         (fit_q[POP-1] >= $past(fit_q[POP-1]) && fit_q[POP-2] >= $past(fit_q[POP-2]))); // R7

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(!busy) && !$past(load_en) && !$past(kid_valid && kid_ready) && $stable(rd_idx))
         |-> $stable(rd_fit)); // R8

   for (genvar i = 0; i < POP - 1; i++) begin : g_ord
      AST_READY_ORDERED: assert property (@(posedge clk) disable iff (!rst_n)
         kid_ready |-> (fit_q[i] >= fit_q[i+1])); // R4
   end
endmodule

bind elite_pool elite_pool_chk #(.POP(POP), .FW(FIT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy      (busy),
   .kid_ready (kid_ready),
   .kid_valid (kid_valid),
   .load_en   (load_en),
   .rd_idx    (rd_idx),
   .rd_fit    (rd_fit),
   .fit_q     (fit_q),
   .rep       (rep)
);

// File: tb/elite_pool_tb.sv
module elite_pool_tb;
   localparam int CLK_PERIOD = 10;
   localparam int POP = 32;
   localparam int CW  = 16;
   localparam int FW  = 16;
   localparam int IW  = 5;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          load_en, sort_go, kid_valid;
   logic [IW-1:0] load_idx, rd_idx;
   logic [CW-1:0] load_chrom, kid_a_chrom, kid_b_chrom, rd_chrom;
   logic [FW-1:0] load_fit, kid_a_fit, kid_b_fit, rd_fit;
   logic          kid_ready, busy;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   elite_pool #(.POP(POP), .CHROM_W(CW), .FIT_W(FW)) u_dut (
      .clk (clk), .rst_n (rst_n),
      .load_en (load_en), .load_idx (load_idx), .load_chrom (load_chrom), .load_fit (load_fit),
      .sort_go (sort_go), .rd_idx (rd_idx), .rd_chrom (rd_chrom), .rd_fit (rd_fit),
      .kid_valid (kid_valid), .kid_ready (kid_ready),
      .kid_a_chrom (kid_a_chrom), .kid_a_fit (kid_a_fit),
      .kid_b_chrom (kid_b_chrom), .kid_b_fit (kid_b_fit),
      .busy (busy)
   );

   // Behavioural reference model.
   logic [CW-1:0] m_chrom [POP];
   logic [FW-1:0] m_fit   [POP];
   int            m_busy_left;
   bit            m_ok, m_pend;

   task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_sort();
      for (int i = 1; i < POP; i++) begin
         logic [CW-1:0] kc;
         logic [FW-1:0] kf;
         int j;
         kc = m_chrom[i];
         kf = m_fit[i];
         j  = i - 1;
         while (j >= 0 && m_fit[j] < kf) begin
            m_chrom[j+1] = m_chrom[j];
            m_fit[j+1]   = m_fit[j];
            j--;
         end
         m_chrom[j+1] = kc;
         m_fit[j+1]   = kf;
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < POP; i++) begin
            m_chrom[i] = '0;
            m_fit[i]   = '0;
         end
         m_busy_left = 0;
         m_ok = 1'b1;
         m_pend = 1'b0;
      end else begin
         bit idle, rdy, start, acc, w_hi, w_lo, b_up;
         logic [CW-1:0] hc, lc;
         logic [FW-1:0] hf, lf;
         idle  = (m_busy_left == 0);
         rdy   = idle && m_ok && !m_pend;
         start = idle && (sort_go || m_pend);
         acc   = kid_valid && rdy;
         b_up  = kid_b_fit > kid_a_fit;
         hc = b_up ? kid_b_chrom : kid_a_chrom;
         hf = b_up ? kid_b_fit   : kid_a_fit;
         lc = b_up ? kid_a_chrom : kid_b_chrom;
         lf = b_up ? kid_a_fit   : kid_b_fit;
         w_hi = acc && (hf > m_fit[POP-2]);
         w_lo = acc && (lf > m_fit[POP-1]);
         if (idle && load_en) begin
            m_chrom[load_idx] = load_chrom;
            m_fit[load_idx]   = load_fit;
            m_ok = 1'b0;
         end
         if (w_hi) begin m_chrom[POP-2] = hc; m_fit[POP-2] = hf; end
         if (w_lo) begin m_chrom[POP-1] = lc; m_fit[POP-1] = lf; end
         if (w_hi || w_lo) m_pend = 1'b1;
         else if (start)   m_pend = 1'b0;
         if (start) begin
            m_busy_left = POP;
         end else if (m_busy_left > 0) begin
            m_busy_left--;
            if (m_busy_left == 0) begin
               model_sort();
               m_ok = 1'b1;
            end
         end
      end
   end

   // Compare on every clock, half a period away from the active edge.
   always @(negedge clk) begin
      if (rst_n) begin
         check("R4 busy", busy, m_busy_left != 0);
         check("R6 kid_ready", kid_ready, (m_busy_left == 0) && m_ok && !m_pend);
         if (m_busy_left == 0) begin
            check("R2 rd_fit", rd_fit, m_fit[rd_idx]);
            check("R5 rd_chrom", rd_chrom, m_chrom[rd_idx]);
         end
      end
   end

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic sweep();
      for (int i = 0; i < POP; i++) begin
         rd_idx = IW'(i);
         tick();
      end
   endtask

   task automatic load_slot(int idx, logic [CW-1:0] c, logic [FW-1:0] f);
      load_en = 1'b1; load_idx = IW'(idx); load_chrom = c; load_fit = f;
      tick();
      load_en = 1'b0;
   endtask

   task automatic wait_idle();
      for (int g = 0; g < 200 && (busy || m_pend); g++) tick();
   endtask

   task automatic offer(logic [CW-1:0] ac, logic [FW-1:0] af, logic [CW-1:0] bc, logic [FW-1:0] bf);
      kid_valid = 1'b1;
      kid_a_chrom = ac; kid_a_fit = af; kid_b_chrom = bc; kid_b_fit = bf;
      tick();
      kid_valid = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL R4 watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      int cnt;
      logic [FW-1:0] w2, w1;
      logic [CW-1:0] c2, c1;
      rst_n = 1'b0; load_en = 1'b0; sort_go = 1'b0; kid_valid = 1'b0;
      load_idx = '0; load_chrom = '0; load_fit = '0; rd_idx = '0;
      kid_a_chrom = '0; kid_a_fit = '0; kid_b_chrom = '0; kid_b_fit = '0;
      repeat (3) tick();
      rst_n = 1'b1;
      #1;
      // R1: reset state
      check("R1 busy", busy, 0);
      check("R1 kid_ready", kid_ready, 1);
      sweep();
      check("R1 slot0 fit", {16'h0, m_fit[0]}, 0);

      // R2/R3: load a population full of duplicate fitness values
      for (int i = 0; i < POP; i++) load_slot(i, CW'(16'hA000 + i), FW'(((i * 37) % 11) * 1000));
      check("R3 ready after load", kid_ready, 0);
      rd_idx = 5;
      #1 check("R2 read slot5", rd_fit, FW'(((5 * 37) % 11) * 1000));

      // R4/R10: sort, with a second request, a load and an offer mid-sort
      sort_go = 1'b1;
      tick();
      sort_go = 1'b0;
      check("R4 busy on start", busy, 1);
      cnt = 0;
      while (busy && cnt < 100) begin
         cnt++;
         if (cnt == 5) begin load_en = 1'b1; load_idx = 3; load_chrom = 16'hDEAD; load_fit = 16'hFFFF; end
         if (cnt == 6) load_en = 1'b0;
         if (cnt == 7) begin
            check("R6 ready during sort", kid_ready, 0);
            kid_valid = 1'b1; kid_a_fit = 16'hFFFF; kid_b_fit = 16'hFFFF;
         end
         if (cnt == 8) kid_valid = 1'b0;
         if (cnt == 10) sort_go = 1'b1;
         if (cnt == 11) sort_go = 1'b0;
         tick();
      end
      check("R10 busy length", cnt, POP);
      check("R3 ready after sort", kid_ready, 1);
      sweep();
      for (int i = 1; i < POP; i++) begin
         rd_idx = IW'(i - 1);
         #1 w2 = rd_fit;
         rd_idx = IW'(i);
         #1 check("R4 descending", (w2 >= rd_fit), 1);
      end

      // R8: children equal to the weak slots are refused, no sort starts
      w2 = m_fit[POP-2]; w1 = m_fit[POP-1]; c2 = m_chrom[POP-2]; c1 = m_chrom[POP-1];
      offer(16'h1111, w2, 16'h2222, w1);
      rd_idx = IW'(POP - 2);
      #1 check("R8 slot30 kept", rd_chrom, c2);
      check("R8 no resort", kid_ready, 1);
      tick();
      check("R8 not busy", busy, 0);

      // R7: B fitter goes to slot POP-2; A too weak for slot POP-1
      w1 = m_fit[POP-1];
      offer(16'h3333, w1, 16'h4444, 16'hF000);
      rd_idx = IW'(POP - 2);
      #1 check("R7 hi child in slot30", rd_chrom, 16'h4444);
      rd_idx = IW'(POP - 1);
      #1 check("R7 lo child refused", rd_fit, w1);
      check("R9 ready drops", kid_ready, 0);
      tick();
      check("R9 sort started", busy, 1);
      wait_idle();

      // R7: tie between children, both beat the weak slots, A takes slot POP-2
      offer(16'h5555, 16'hF800, 16'h6666, 16'hF800);
      rd_idx = IW'(POP - 2);
      #1 check("R7 tie A to slot30", rd_chrom, 16'h5555);
      rd_idx = IW'(POP - 1);
      #1 check("R7 tie B to slot31", rd_chrom, 16'h6666);
      wait_idle();
      sweep();

      // Random pairs with a reference compare every clock
      for (int k = 0; k < 150; k++) begin
         rd_idx = IW'($urandom_range(0, POP - 1));
         offer(CW'($urandom), FW'($urandom_range(0, 65535)), CW'($urandom), FW'($urandom_range(0, 65535)));
         wait_idle();
      end
      sweep();

      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule